// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block sits on the host side of a 16-bit successive-approximation converter that has a serial digital interface. When it gets a start request, it pulses the read/convert select low to begin a conversion. It then opens a read window and shifts in the converter's stored result over a gated read clock, most significant bit first. It returns to idle once the converter's active-low busy line goes high again. The word it reads in any cycle is the result of the previous conversion, so the read overlaps the conversion that is running. Each finished word appears on a parallel output with a one-cycle valid strobe.

There are three ways to use the interface:

- **Dedicated select.** Chip select is driven low ahead of each conversion, with a fixed setup time.
- **Tied-low select.** Chip select stays low the whole time, and the read/convert line alone picks the operation.
- **Continuous clock.** The read clock runs all the time, and capture lines up with a frame-sync pulse from the converter. In this mode chip select is always driven.

The first word after reset cannot be trusted. It is read and thrown away. If busy stays low too long, the cycle is aborted and an error flag is raised.

Top module: `adc_rd_ctrl`

## Requirements
- R1: In dedicated-select mode, an accepted start drives cs_no low for exactly CS_SETUP cycles before rd_conv_o falls. In every mode rd_conv_o then stays low for exactly CONV_PULSE cycles (low = convert, high = read).
- R2: The returned word is built from sdata_i sampled on each edge where dclk_o goes back to its idle level. The first bit sampled becomes bit 15 of data_o (MSB first, straight binary).
- R3: With the continuous clock off, each read gives exactly 16 read-clock pulses. Outside a read, dclk_o rests at the level of clk_idle_hi_i (1 = idle high).
- R4: The read starts right after rd_conv_o rises, while busy_ni is still low. The word delivered by a cycle is the result of the conversion started by the cycle before it.
- R5: The first cycle to complete after reset raises no valid_o and leaves data_o unchanged.
- R6: In tied-low mode (cs_tied_i = 1, cont_clk_i = 0), cs_no never goes high.
- R7: With cont_clk_i = 1, dclk_o toggles even while idle, and cs_no is driven high between cycles whatever cs_tied_i is. Capture starts on the sample edge that follows the one where sync_i was seen high.
- R8: valid_o is a single-cycle pulse. It is raised only after busy_ni has been seen high at the end of a cycle. data_o changes only together with valid_o.
- R9: If busy_ni is low for BUSY_LIMIT cycles within one cycle, err_o goes high, the controller goes back to idle (rd_conv_o high, and cs_no high in dedicated mode), and no valid_o is raised. The next accepted start clears err_o.
- R10: A start_i pulse during a cycle in progress starts no extra conversion and produces no extra word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, ignored while a cycle runs |
| cs_tied_i | input | 1 | 1 = chip select held low, read/convert alone selects |
| cont_clk_i | input | 1 | 1 = free-running read clock with frame-sync alignment |
| clk_idle_hi_i | input | 1 | Idle level of the read clock |
| busy_ni | input | 1 | Converter busy, low while converting |
| sdata_i | input | 1 | Serial result data |
| sync_i | input | 1 | Frame sync from the converter |
| rd_conv_o | output | 1 | Read/convert select, low starts a conversion |
| cs_no | output | 1 | Chip select, active low |
| dclk_o | output | 1 | Read clock |
| data_o | output | DATA_W | Last delivered result |
| valid_o | output | 1 | One-cycle strobe with a new data_o |
| err_o | output | 1 | Busy timeout flag |

## Verification
The hardest case to reach from the ports is a conversion that never ends. A stand-in converter that behaves normally will always raise busy again before the limit. To get there, the bench's converter model has a hold flag that keeps busy low until the controller has timed out. The bench then releases the flag and checks that the held conversion's result comes out in the next cycle. The overlapped read is also hard to observe. The bench records busy at the first read-clock pulse of each cycle, and it draws conversion lengths at random so that the read sometimes ends before busy returns and sometimes after.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CONV,
    ST_READ,
    ST_WAIT
  } rd_state_e;
endpackage

// File: rtl/adc_rd_clkgen.sv
// Gated read clock: phase 0 = idle level, leaving idle launches, returning samples.
module adc_rd_clkgen #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic phase_o,
  output logic sample_o
);
  localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [TW-1:0] tick_q;
  logic          phase_q;
  logic          run;
  logic          wrap;

  assign run  = en_i || phase_q;
  assign wrap = (tick_q == TW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q  <= '0;
      phase_q <= 1'b0;
    end else if (run) begin
      if (wrap) begin
        tick_q  <= '0;
        phase_q <= !phase_q;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end else begin
      tick_q <= '0;
    end
  end

  assign phase_o  = phase_q;
  assign sample_o = run && wrap && phase_q;
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         samp_i,
  input  logic         sync_mode_i,
  input  logic         sdata_i,
  input  logic         sync_i,
  output logic [W-1:0] word_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          armed_q;

  assign done_o = (cnt_q == CW'(W));
  assign word_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (samp_i && !done_o) begin
      if (!sync_mode_i || armed_q) begin
        sh_q  <= {sh_q[W-2:0], sdata_i};
        cnt_q <= cnt_q + 1'b1;
      end else if (sync_i) begin
        armed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_rd_tmo.sv
module adc_rd_tmo #(
  parameter int LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = en_i && (cnt_q >= CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (en_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CS_SETUP   = 2,
  parameter int CONV_PULSE = 2,
  parameter int SCLK_HALF  = 2,
  parameter int BUSY_LIMIT = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cs_tied_i,
  input  logic              cont_clk_i,
  input  logic              clk_idle_hi_i,
  input  logic              busy_ni,
  input  logic              sdata_i,
  input  logic              sync_i,
  output logic              rd_conv_o,
  output logic              cs_no,
  output logic              dclk_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int PMAX = (CS_SETUP > CONV_PULSE) ? CS_SETUP : CONV_PULSE;
  localparam int PW   = $clog2(PMAX + 1);

  rd_state_e         state_q;
  logic [PW-1:0]     ph_cnt_q;
  logic              primed_q;
  logic              dedicated;
  logic              accept;
  logic              clk_en;
  logic              phase;
  logic              sample;
  logic              sh_done;
  logic [DATA_W-1:0] sh_word;
  logic              tmo_en;
  logic              tmo_hit;

  assign dedicated = !cs_tied_i || cont_clk_i;
  assign accept    = (state_q == ST_IDLE) && start_i;
  assign clk_en    = cont_clk_i || ((state_q == ST_READ) && !sh_done);
  assign tmo_en    = !busy_ni &&
                     (state_q == ST_CONV || state_q == ST_READ || state_q == ST_WAIT);

  assign rd_conv_o = (state_q != ST_CONV);
  assign cs_no     = dedicated ? (state_q == ST_IDLE) : 1'b0;
  assign dclk_o    = phase ^ clk_idle_hi_i;

  adc_rd_clkgen #(.HALF(SCLK_HALF)) u_clkgen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (clk_en),
    .phase_o  (phase),
    .sample_o (sample)
  );

  adc_rd_shifter #(.W(DATA_W)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (state_q == ST_CONV),
    .samp_i      (sample && (state_q == ST_READ)),
    .sync_mode_i (cont_clk_i),
    .sdata_i     (sdata_i),
    .sync_i      (sync_i),
    .word_o      (sh_word),
    .done_o      (sh_done)
  );

  adc_rd_tmo #(.LIMIT(BUSY_LIMIT)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .en_i      (tmo_en),
    .expired_o (tmo_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ph_cnt_q <= '0;
      primed_q <= 1'b0;
      data_o   <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tmo_hit) begin
        err_o   <= 1'b1;
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_i) begin
            err_o    <= 1'b0;
            ph_cnt_q <= '0;
            state_q  <= dedicated ? ST_SETUP : ST_CONV;
          end
          ST_SETUP: begin
            if (ph_cnt_q == PW'(CS_SETUP - 1)) begin
              ph_cnt_q <= '0;
              state_q  <= ST_CONV;
            end else begin
              ph_cnt_q <= ph_cnt_q + 1'b1;
            end
          end
          ST_CONV: begin
            if (ph_cnt_q == PW'(CONV_PULSE - 1)) begin
              ph_cnt_q <= '0;
              state_q  <= ST_READ;
            end else begin
              ph_cnt_q <= ph_cnt_q + 1'b1;
            end
          end
          ST_READ: if (sh_done) state_q <= ST_WAIT;
          ST_WAIT: if (busy_ni) begin
            // first word after reset is indeterminate: drop it
            if (primed_q) begin
              data_o  <= sh_word;
              valid_o <= 1'b1;
            end
            primed_q <= 1'b1;
            state_q  <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_tied_i,
  input logic              cont_clk_i,
  input logic              clk_idle_hi_i,
  input logic              busy_ni,
  input logic              rd_conv_o,
  input logic              cs_no,
  input logic              dclk_o,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              err_o
);
  assert_cs_setup_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_conv_o) && (!cs_tied_i || cont_clk_i)) |-> (!cs_no && !$past(cs_no)));

  assert_clk_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cont_clk_i && !rd_conv_o) |-> (dclk_o == clk_idle_hi_i));

  assert_tied_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_tied_i && !cont_clk_i && !rd_conv_o) |-> !cs_no);

  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_valid_after_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(busy_ni));

  assert_data_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  assert_err_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (rd_conv_o && !valid_o));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_tied_i     (cs_tied_i),
  .cont_clk_i    (cont_clk_i),
  .clk_idle_hi_i (clk_idle_hi_i),
  .busy_ni       (busy_ni),
  .rd_conv_o     (rd_conv_o),
  .cs_no         (cs_no),
  .dclk_o        (dclk_o),
  .data_o        (data_o),
  .valid_o       (valid_o),
  .err_o         (err_o)
);

// File: tb/adc_rd_ctrl_test.sv
module adc_rd_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CS_SETUP   = 2;
  localparam int CONV_PULSE = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        cs_tied_i = 1'b0;
  logic        cont_clk_i = 1'b0;
  logic        clk_idle_hi_i = 1'b0;
  logic        busy_ni;
  logic        sdata_i;
  logic        sync_i;
  logic        rd_conv_o, cs_no, dclk_o, valid_o, err_o;
  logic [15:0] data_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_rd_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .cs_tied_i(cs_tied_i),
    .cont_clk_i(cont_clk_i), .clk_idle_hi_i(clk_idle_hi_i), .busy_ni(busy_ni),
    .sdata_i(sdata_i), .sync_i(sync_i), .rd_conv_o(rd_conv_o), .cs_no(cs_no),
    .dclk_o(dclk_o), .data_o(data_o), .valid_o(valid_o), .err_o(err_o)
  );

  // behavioural converter stand-in
  logic [15:0] next_sample;
  int          conv_len;
  logic        m_stuck = 1'b0;
  logic [15:0] m_result, m_cur, m_sh;
  logic        m_prev_rc, m_prev_dclk, m_pend;
  int          m_left, m_bits, m_convs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_ni <= 1'b1; sdata_i <= 1'b0; sync_i <= 1'b0;
      m_result <= 16'hdead; m_cur <= '0; m_sh <= '0; m_pend <= 1'b0;
      m_prev_rc <= 1'b1; m_prev_dclk <= 1'b0; m_left <= 0; m_bits <= 0; m_convs <= 0;
    end else begin
      m_prev_rc   <= rd_conv_o;
      m_prev_dclk <= dclk_o;
      if (m_prev_rc && !rd_conv_o && !cs_no) begin
        busy_ni <= 1'b0; m_left <= conv_len; m_cur <= next_sample; m_convs <= m_convs + 1;
      end else if (!busy_ni) begin
        if (m_left > 0) m_left <= m_left - 1;
        else if (!m_stuck) begin busy_ni <= 1'b1; m_result <= m_cur; end
      end
      if (!m_prev_rc && rd_conv_o && !cs_no) begin
        m_sh <= m_result; m_bits <= 16; m_pend <= cont_clk_i; sdata_i <= 1'b0; sync_i <= 1'b0;
      end else if (dclk_o != clk_idle_hi_i && m_prev_dclk == clk_idle_hi_i) begin
        if (m_pend) begin
          sync_i <= 1'b1; m_pend <= 1'b0;
        end else begin
          sync_i <= 1'b0;
          if (m_bits > 0) begin
            sdata_i <= m_sh[15]; m_sh <= {m_sh[14:0], 1'b0}; m_bits <= m_bits - 1;
          end else sdata_i <= 1'b0;
        end
      end
    end
  end

  // port monitor, sampled on the falling edge
  int          vcount = 0, setup_cnt, conv_w, pulses, toggles;
  logic [15:0] last_data = '0;
  logic        seen_conv, cs_hi_seen, overlap, mon_prev_dclk = 1'b0;

  always @(negedge clk) begin
    if (valid_o) begin vcount++; last_data = data_o; end
    if (!cs_no && rd_conv_o && !seen_conv) setup_cnt++;
    if (!rd_conv_o) begin conv_w++; seen_conv = 1'b1; end
    if (cs_no) cs_hi_seen = 1'b1;
    if (dclk_o != mon_prev_dclk) toggles++;
    if (dclk_o != clk_idle_hi_i && mon_prev_dclk == clk_idle_hi_i) begin
      if (pulses == 0) overlap = !busy_ni;
      pulses++;
    end
    mon_prev_dclk = dclk_o;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_cs_driven(input int mode, input bit tied);
    return (mode != 1) || (mode == 2 && tied);
  endfunction

  logic [15:0] last_sample = '0;
  bit          primed = 1'b0;
  bit          err_pending = 1'b0;

  // mode 0: discontinuous, dedicated select; 1: discontinuous, tied low; 2: continuous
  task automatic run_cycle(input int mode, input bit idle_hi, input bit stuck, input bit extra);
    int v0, c0;
    bit tied;
    tied = (mode == 1) || (mode == 2 && ($urandom % 2 == 1));
    @(negedge clk);
    cs_tied_i = tied; cont_clk_i = (mode == 2); clk_idle_hi_i = idle_hi;
    toggles = 0;
    repeat (10) @(negedge clk);
    if (mode == 2) begin
      chk("R7", "idle clock toggles", int'(toggles > 0), 1);
      chk("R7", "cs high between cycles", cs_no, 1);
    end else if (mode == 0) begin
      chk("R3", "idle clock level", dclk_o, idle_hi);
    end
    next_sample = 16'($urandom); conv_len = 20 + int'($urandom % 40); m_stuck = stuck;
    setup_cnt = 0; conv_w = 0; pulses = 0; seen_conv = 1'b0; cs_hi_seen = 1'b0; overlap = 1'b0;
    v0 = vcount; c0 = m_convs;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    if (err_pending) begin chk("R9", "err cleared by start", err_o, 0); err_pending = 1'b0; end
    if (extra) begin
      repeat (30) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      repeat (170) @(negedge clk);
    end else begin
      repeat (200) @(negedge clk);
    end
    chk("R10", "one conversion per accepted start", m_convs - c0, 1);
    chk("R1", "convert pulse width", conv_w, CONV_PULSE);
    if (mode != 1) chk("R1", "select setup cycles", setup_cnt, CS_SETUP);
    if (stuck) begin
      chk("R9", "timeout flag", err_o, 1);
      chk("R9", "no word on timeout", vcount - v0, 0);
      chk("R9", "back to idle", rd_conv_o && (cs_no == exp_cs_driven(mode, tied)), 1);
      m_stuck = 1'b0;
      repeat (5) @(negedge clk);
      last_sample = next_sample;
      err_pending = 1'b1;
      return;
    end
    chk("R9", "no timeout", err_o, 0);
    if (mode == 1) chk("R6", "select never high", cs_hi_seen, 0);
    if (mode != 2) begin
      chk("R3", "pulses per read", pulses, 16);
      chk("R3", "clock back at idle", dclk_o, idle_hi);
      chk("R4", "read overlaps conversion", overlap, 1);
    end
    if (!primed) begin
      chk("R5", "first word dropped", vcount - v0, 0);
      chk("R5", "data untouched", data_o, 0);
    end else begin
      chk("R8", "one valid per cycle", vcount - v0, 1);
      chk(mode == 2 ? "R7" : "R2", "word value", last_data, last_sample);
      chk("R4", "data is previous conversion", data_o, last_sample);
    end
    primed = 1'b1;
    last_sample = next_sample;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "reset err", err_o, 0);
    chk("R8", "reset valid", valid_o, 0);
    chk("R1", "reset read/convert high", rd_conv_o, 1);
    chk("R1", "reset select high", cs_no, 1);
    chk("R3", "reset clock idle", dclk_o, 0);
    run_cycle(0, 1'b0, 1'b0, 1'b0);
    run_cycle(0, 1'b1, 1'b0, 1'b0);
    run_cycle(1, 1'b0, 1'b0, 1'b0);
    run_cycle(2, 1'b0, 1'b0, 1'b0);
    run_cycle(0, 1'b0, 1'b0, 1'b1);
    run_cycle(0, 1'b1, 1'b1, 1'b0);
    run_cycle(1, 1'b1, 1'b0, 1'b0);
    run_cycle(2, 1'b1, 1'b1, 1'b0);
    run_cycle(2, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 30; i++) begin
      run_cycle(int'($urandom % 3), 1'($urandom), ($urandom % 8) == 0, ($urandom % 4) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule